// File: doc/BRIEF.md
# LCD Panel Power Sequencing Gate

This block sits between the timing generator of a colour LCD controller and the panel pins. It holds five timing lines and 24 pixel data lines low until software brings the panel up in two stages. The timing lines are the line pulse, the pixel clock, the frame pulse, the AC bias and the line end. In the first stage, setting the controller-enable bit releases the timing lines. In the second stage, setting the panel-power bit raises the panel power output and releases the pixel data.

A programmable minimum delay, counted in clock cycles from the enable, must run out before a panel-power request takes effect. A request that arrives early is held as pending until the delay runs out. Power-down runs in the reverse order. If software clears the enable bit while the panel is still powered, the block splits that write into two steps. On the first clock it removes power and data. One clock later it forces the timing lines low, so the reverse order always holds.

Every pin is registered. A qualifying register write therefore changes the pins at the clock edge that samples the write, and the pins follow the generator inputs with one clock of latency.

Top module: `lcd_pwr_gate`

## Requirements
- R1: After reset the five timing pins, all pixel data pins and the panel power pin are low, and both registers read back as zero.
- R2: Register address 0 is control. On write, bit 0 is controller-enable and bit 1 is panel-power. On read, bit 0 is the current enable, bit 1 is the current panel power, bit 2 is power-pending, and the other bits are zero. Address 1 is the delay register: its low 16 bits are stored and read back, and its upper bits read as zero.
- R3: A control write with bit 0 set, while the block is disabled, drives the timing pins to the generator values from that clock edge onward. The pixel data pins stay zero.
- R4: While panel power is effective, the panel power pin is high and the data pins carry the generator pixel data.
- R5: A panel-power request is ignored when the enable was clear before the write, including a write that sets both bits at once. The power pin stays low and no request is kept pending.
- R6: After an enabling write at edge k with delay value D, power turns on at edge max(k+o, k+D+1), where the power request is written at edge k+o. While the request waits, the pending bit reads 1.
- R7: A control write that keeps bit 0 set and clears bit 1 drops the power pin and zeroes the data pins at that edge, and leaves the timing pins active. A later write of 0 then forces the timing pins low.
- R8: Clearing bit 0 while power is on drops power and data at the write edge. The timing pins go low one edge later. Any control write sampled during that second edge is ignored.
- R9: The pins are registered copies of the gated generator inputs, so a change on a generator input appears on the pins one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 delay |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| gen_lp | input | 1 | Line pulse from the timing generator |
| gen_cp | input | 1 | Pixel clock from the timing generator |
| gen_fp | input | 1 | Frame pulse from the timing generator |
| gen_ac | input | 1 | AC bias from the timing generator |
| gen_le | input | 1 | Line end from the timing generator |
| gen_data | input | 24 | Pixel data from the timing generator |
| pin_lp | output | 1 | Gated line pulse |
| pin_cp | output | 1 | Gated pixel clock |
| pin_fp | output | 1 | Gated frame pulse |
| pin_ac | output | 1 | Gated AC bias |
| pin_le | output | 1 | Gated line end |
| pin_data | output | 24 | Gated pixel data |
| pin_pwr | output | 1 | Panel power enable |

## Verification
A wrong enable or power state shows up on the pins at the very next clock edge. A wrong delay count shows up as power rising one or more edges early or late, and as a pending bit that disagrees with the cycle. The bench sweeps every delay value from 0 to 4 against every request offset around that delay, and checks the power pin and the pending bit each cycle. A broken split power-down shows up as timing pins that either go low in the same edge as power or never go low at all. Both cases are visible one edge after the clearing write.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;
  localparam int BUS_W   = 32;
  localparam int CTRL_N  = 5;
  localparam int BIT_EN  = 0;
  localparam int BIT_PWR = 1;
  localparam int BIT_PND = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DLY  = 1'b1;
endpackage

// File: rtl/lcd_pwr_regs.sv
module lcd_pwr_regs
  import lcd_pwr_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             en_q,
  input  logic             pwr_q,
  input  logic             pending,
  output logic [DLY_W-1:0] dly_q,
  output logic             wr_ctrl,
  output logic             wr_en_bit,
  output logic             wr_pwr_bit
);
  localparam int PAD_W = BUS_W - DLY_W;

  always_ff @(posedge clk) begin
    if (rst) dly_q <= '0;
    else if (reg_wr && reg_addr == ADDR_DLY) dly_q <= reg_wdata[DLY_W-1:0];
  end

  assign wr_ctrl    = reg_wr && reg_addr == ADDR_CTRL;
  assign wr_en_bit  = reg_wdata[BIT_EN];
  assign wr_pwr_bit = reg_wdata[BIT_PWR];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_DLY) begin
      reg_rdata = {{PAD_W{1'b0}}, dly_q};
    end else begin
      reg_rdata[BIT_EN]  = en_q;
      reg_rdata[BIT_PWR] = pwr_q;
      reg_rdata[BIT_PND] = pending;
    end
  end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_en_bit,
  input  logic             wr_pwr_bit,
  input  logic [DLY_W-1:0] dly_val,
  output logic             en_nxt,
  output logic             pwr_nxt,
  output logic             en_q,
  output logic             pwr_q,
  output logic             pending
);
  logic             req_q, req_nxt, drop_q, drop_nxt, load;
  logic [DLY_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    en_nxt   = en_q;
    req_nxt  = req_q;
    drop_nxt = 1'b0;
    load     = 1'b0;
    if (drop_q) begin
      en_nxt  = 1'b0;
      req_nxt = 1'b0;
    end else if (wr_ctrl) begin
      if (!wr_en_bit && pwr_q) begin
        req_nxt  = 1'b0;
        drop_nxt = 1'b1;
      end else begin
        en_nxt  = wr_en_bit;
        req_nxt = wr_en_bit && wr_pwr_bit && en_q;
        load    = wr_en_bit && !en_q;
      end
    end
    pwr_nxt = req_nxt && en_nxt && en_q && cnt_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      req_q  <= 1'b0;
      pwr_q  <= 1'b0;
      drop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_nxt;
      req_q  <= req_nxt;
      pwr_q  <= pwr_nxt;
      drop_q <= drop_nxt;
      if (load) cnt_q <= dly_val;
      else if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pending = req_q && !pwr_q;

  AST_PWR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    pwr_q |-> en_q); // R5
  AST_REVERSE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> !$past(pwr_q)); // R8
  AST_DROP_NEXT: assert property (@(posedge clk) disable iff (rst)
    drop_q |=> !en_q); // R8
  AST_DELAY_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_q) |-> cnt_zero); // R6
endmodule

// File: rtl/lcd_pwr_gatereg.sv
module lcd_pwr_gatereg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gate,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= gate ? d : '0;
  end
endmodule

// File: rtl/lcd_pwr_gate.sv
module lcd_pwr_gate
  import lcd_pwr_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             gen_lp,
  input  logic             gen_cp,
  input  logic             gen_fp,
  input  logic             gen_ac,
  input  logic             gen_le,
  input  logic [PIX_W-1:0] gen_data,
  output logic             pin_lp,
  output logic             pin_cp,
  output logic             pin_fp,
  output logic             pin_ac,
  output logic             pin_le,
  output logic [PIX_W-1:0] pin_data,
  output logic             pin_pwr
);
  logic             en_nxt, pwr_nxt, en_q, pwr_q, pending;
  logic             wr_ctrl, wr_en_bit, wr_pwr_bit;
  logic [DLY_W-1:0] dly_q;
  logic [CTRL_N-1:0] ctrl_in, ctrl_out;

  lcd_pwr_regs #(.DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en_q(en_q),
    .pwr_q(pwr_q), .pending(pending), .dly_q(dly_q), .wr_ctrl(wr_ctrl),
    .wr_en_bit(wr_en_bit), .wr_pwr_bit(wr_pwr_bit)
  );

  lcd_pwr_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_en_bit(wr_en_bit),
    .wr_pwr_bit(wr_pwr_bit), .dly_val(dly_q), .en_nxt(en_nxt),
    .pwr_nxt(pwr_nxt), .en_q(en_q), .pwr_q(pwr_q), .pending(pending)
  );

  assign ctrl_in = {gen_lp, gen_cp, gen_fp, gen_ac, gen_le};

  lcd_pwr_gatereg #(.W(CTRL_N)) u_ctrl_reg (
    .clk(clk), .rst(rst), .gate(en_nxt), .d(ctrl_in), .q(ctrl_out)
  );

  lcd_pwr_gatereg #(.W(PIX_W)) u_data_reg (
    .clk(clk), .rst(rst), .gate(pwr_nxt), .d(gen_data), .q(pin_data)
  );

  assign {pin_lp, pin_cp, pin_fp, pin_ac, pin_le} = ctrl_out;
  assign pin_pwr = pwr_q;

  AST_CTRL_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> ctrl_out == '0); // R3
  AST_DATA_LOW_NOPWR: assert property (@(posedge clk) disable iff (rst)
    !pin_pwr |-> pin_data == '0); // R4
  AST_CTRL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q) && !$past(rst)) |-> ctrl_out == $past(ctrl_in)); // R9
endmodule

// File: tb/lcd_pwr_gate_bench.sv
module lcd_pwr_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        gen_lp = 1'b1, gen_cp = 1'b1, gen_fp = 1'b1, gen_ac = 1'b1, gen_le = 1'b1;
  logic [23:0] gen_data = 24'hA5C3F1;
  logic        pin_lp, pin_cp, pin_fp, pin_ac, pin_le, pin_pwr;
  logic [23:0] pin_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  lcd_pwr_gate u_lcd_pwr_gate (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gen_lp(gen_lp),
    .gen_cp(gen_cp), .gen_fp(gen_fp), .gen_ac(gen_ac), .gen_le(gen_le),
    .gen_data(gen_data), .pin_lp(pin_lp), .pin_cp(pin_cp), .pin_fp(pin_fp),
    .pin_ac(pin_ac), .pin_le(pin_le), .pin_data(pin_data), .pin_pwr(pin_pwr)
  );

  function automatic logic [4:0] ctrl_pins();
    return {pin_lp, pin_cp, pin_fp, pin_ac, pin_le};
  endfunction

  function automatic logic [4:0] ctrl_gen();
    return {gen_lp, gen_cp, gen_fp, gen_ac, gen_le};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic addr, input logic [31:0] data);
    reg_wr = wr; reg_addr = addr; reg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd(input logic addr, input string tag, input logic [31:0] exp);
    reg_addr = addr;
    #0.5;
    chk(tag, reg_rdata, exp);
    reg_addr = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ctrl pins", {27'd0, ctrl_pins()}, 32'd0);
    chk("R1 data", {8'd0, pin_data}, 32'd0);
    chk("R1 pwr", {31'd0, pin_pwr}, 32'd0);
    rd(1'b0, "R1 ctrl read", 32'd0);
    rd(1'b1, "R1 dly read", 32'd0);
    // R2 delay register width
    step(1'b1, 1'b1, 32'hFFFF_BEEF);
    rd(1'b1, "R2 dly readback", 32'h0000_BEEF);
    step(1'b1, 1'b1, 32'd0);
    // R5 power while disabled
    step(1'b1, 1'b0, 32'd2);
    chk("R5 pwr only", {31'd0, pin_pwr}, 32'd0);
    rd(1'b0, "R5 read after pwr only", 32'd0);
    step(1'b1, 1'b0, 32'd3);
    chk("R5 both bits pwr", {31'd0, pin_pwr}, 32'd0);
    rd(1'b0, "R5 read both bits", 32'd1);
    // R3 timing lines live, data low
    chk("R3 ctrl live", {27'd0, ctrl_pins()}, 32'h1F);
    chk("R3 data low", {8'd0, pin_data}, 32'd0);
    step(1'b1, 1'b0, 32'd0);
    chk("R7 ctrl low after disable", {27'd0, ctrl_pins()}, 32'd0);

    // R6/R4 sweep of delay versus request offset
    for (int d = 0; d <= 4; d++) begin
      for (int o = 1; o <= d + 2; o++) begin
        int on_at;
        on_at = (o > d + 1) ? o : d + 1;
        step(1'b1, 1'b1, d);
        step(1'b1, 1'b0, 32'd1);
        for (int s = 1; s <= d + 3; s++) begin
          bit exp_on, exp_pnd;
          if (s == o) step(1'b1, 1'b0, 32'd3);
          else        step(1'b0, 1'b0, 32'd0);
          exp_on  = (s >= on_at);
          exp_pnd = (s >= o) && !exp_on;
          chk($sformatf("R6 pwr d=%0d o=%0d s=%0d", d, o, s), {31'd0, pin_pwr}, {31'd0, exp_on});
          chk($sformatf("R4 data d=%0d o=%0d s=%0d", d, o, s), {8'd0, pin_data},
              exp_on ? {8'd0, gen_data} : 32'd0);
          rd(1'b0, $sformatf("R6 read d=%0d o=%0d s=%0d", d, o, s),
             {29'd0, exp_pnd, exp_on, 1'b1});
        end
        // R7 ordered power-down
        step(1'b1, 1'b0, 32'd1);
        chk("R7 pwr off", {31'd0, pin_pwr}, 32'd0);
        chk("R7 data off", {8'd0, pin_data}, 32'd0);
        chk("R7 ctrl kept", {27'd0, ctrl_pins()}, 32'h1F);
        step(1'b1, 1'b0, 32'd0);
        chk("R7 ctrl low", {27'd0, ctrl_pins()}, 32'd0);
      end
    end

    // R8 clearing enable while powered
    step(1'b1, 1'b1, 32'd0);
    step(1'b1, 1'b0, 32'd1);
    step(1'b1, 1'b0, 32'd3);
    chk("R8 powered", {31'd0, pin_pwr}, 32'd1);
    step(1'b1, 1'b0, 32'd0);
    chk("R8 pwr first", {31'd0, pin_pwr}, 32'd0);
    chk("R8 data first", {8'd0, pin_data}, 32'd0);
    chk("R8 ctrl still live", {27'd0, ctrl_pins()}, 32'h1F);
    rd(1'b0, "R8 en still set", 32'd1);
    step(1'b1, 1'b0, 32'd3);
    chk("R8 ctrl low next", {27'd0, ctrl_pins()}, 32'd0);
    rd(1'b0, "R8 write ignored", 32'd0);
    step(1'b0, 1'b0, 32'd0);
    rd(1'b0, "R8 stays off", 32'd0);

    // R9 one clock of latency
    step(1'b1, 1'b0, 32'd1);
    step(1'b1, 1'b0, 32'd3);
    for (int k = 0; k < 4; k++) begin
      logic [23:0] old_d;
      logic [4:0]  old_c;
      old_d = pin_data;
      old_c = ctrl_pins();
      gen_data = 24'h13579B ^ (24'h111111 * k);
      {gen_lp, gen_cp, gen_fp, gen_ac, gen_le} = 5'h0A ^ k[4:0];
      #0.5;
      chk("R9 data before edge", {8'd0, pin_data}, {8'd0, old_d});
      chk("R9 ctrl before edge", {27'd0, ctrl_pins()}, {27'd0, old_c});
      step(1'b0, 1'b0, 32'd0);
      chk("R9 data after edge", {8'd0, pin_data}, {8'd0, gen_data});
      chk("R9 ctrl after edge", {27'd0, ctrl_pins()}, {27'd0, ctrl_gen()});
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule